// File: doc/BRIEF.md
# CPI and Boot Status Monitor

This block watches a processor from the outside and reports how fast it is running. It counts master clock cycles in fixed windows of 2^WIN_LOG2 cycles and counts the instructions that retire in each window. When a window closes, a sequential restoring divider computes the integer average of cycles per instruction. The result is shown as three hexadecimal digits on a multiplexed common-anode 7-segment display. With the default 100 MHz clock the window is about 10.5 ms, and each digit is refreshed at about 1 kHz.

Next to the display, eight status LEDs give the boot stage. The leftmost LED is lit once RAM calibration is done and the sixth LED from the left is lit once boot is done. While the error code input is nonzero, the display shows that code instead of the CPI and the rightmost LED blinks.

All pins are plain control and status signals. There is no streaming interface at the edge, so there is no back-pressure. Inside the block, each window count is handed to the divider over a valid/ready pair. The divider always finishes long before the next window closes, so that handshake never stalls.

Top module: `cpi_status_monitor`

## Requirements
- R1: After reset the display shows value 0x000 with digit 0 selected (`an_o` = 3'b110), and `led_o` is 8'h00.
- R2: Each window is 2^WIN_LOG2 cycles long. When a window closes, the displayed CPI becomes floor(2^WIN_LOG2 / N), where N is the number of cycles in that window with `retire_i` high. The new value appears within WIN_LOG2+4 cycles of the window closing.
- R3: A window with N = 0 gives a displayed CPI of 0xFFF.
- R4: A quotient greater than 0xFFF is shown as 0xFFF.
- R5: Exactly one bit of `an_o` is low at any time. The selected digit advances 0, 1, 2, 0, … every REFRESH_DIV cycles. Digit d shows bits [4d+3:4d] of the shown value, so digit 0 is the least significant nibble. `seg_o` is active low and ordered {g,f,e,d,c,b,a}. The active-high patterns for 0 to F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R6: `led_o[7]` (leftmost) follows `cal_done_i` and `led_o[2]` (sixth from left) follows `boot_done_i`, each one cycle late. `led_o[6:3]` and `led_o[1]` stay 0.
- R7: While `err_code_i` is nonzero, the display shows `err_code_i` in place of the CPI.
- R8: While `err_code_i` is nonzero, `led_o[0]` toggles every BLINK_HALF cycles. While it is zero, `led_o[0]` is 0.
- R9: Once `err_code_i` returns to zero, the display again shows the most recent CPI. That CPI keeps being measured while the error is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | High for one cycle per retired instruction |
| cal_done_i | input | 1 | RAM calibration complete |
| boot_done_i | input | 1 | Boot complete |
| err_code_i | input | 12 | Error code, zero when there is no error |
| seg_o | output | 7 | Segment cathodes {g..a}, active low |
| an_o | output | 3 | Digit anodes, active low, bit 0 is the rightmost digit |
| led_o | output | 8 | Status LEDs, bit 7 is the leftmost |

## Verification
A wrong window length or a miscounted retire shows as a wrong CPI digit within one window plus the divider latency. Because patterns are held for two full windows, a steady wrong value cannot be mistaken for a window that mixes two patterns. A divider that drops a quotient bit, or a saturation that compares against the wrong limit, changes a digit on the first window after the divider finishes. A stuck or skipped digit select shows within three refresh periods as a missing anode or a wrong nibble. Blink and LED faults appear within two blink half-periods.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int DIGITS = 3;
  localparam int VAL_W  = 4 * DIGITS;

  function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
    logic [6:0] s;
    case (nib)
      4'h0: s = 7'h3F;  4'h1: s = 7'h06;  4'h2: s = 7'h5B;  4'h3: s = 7'h4F;
      4'h4: s = 7'h66;  4'h5: s = 7'h6D;  4'h6: s = 7'h7D;  4'h7: s = 7'h07;
      4'h8: s = 7'h7F;  4'h9: s = 7'h6F;  4'hA: s = 7'h77;  4'hB: s = 7'h7C;
      4'hC: s = 7'h39;  4'hD: s = 7'h5E;  4'hE: s = 7'h79;  default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/cpi_window.sv
module cpi_window #(
  parameter int WIN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_i,
  output logic              win_valid_o,
  output logic [WIN_LOG2:0] win_count_o
);
  logic [WIN_LOG2-1:0] cyc_q;
  logic [WIN_LOG2:0]   inst_q;
  logic                last_cyc;

  assign last_cyc = &cyc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q       <= '0;
      inst_q      <= '0;
      win_valid_o <= 1'b0;
      win_count_o <= '0;
    end else begin
      cyc_q       <= cyc_q + 1'b1;
      win_valid_o <= last_cyc;
      if (last_cyc) begin
        win_count_o <= inst_q + {{WIN_LOG2{1'b0}}, retire_i};
        inst_q      <= '0;
      end else begin
        inst_q <= inst_q + {{WIN_LOG2{1'b0}}, retire_i};
      end
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (win_count_o <= ((WIN_LOG2+1)'(1) << WIN_LOG2))); // R2
endmodule

// File: rtl/cpi_divider.sv
module cpi_divider #(
  parameter int WIN_LOG2 = 20,
  parameter int OUT_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WIN_LOG2:0] divisor_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  result_o
);
  localparam int CW = WIN_LOG2 + 1;
  localparam int SW = $clog2(WIN_LOG2 + 2);
  localparam logic [CW-1:0] OUT_MAX = CW'((1 << OUT_W) - 1);

  logic [CW-1:0] dvs_q, dvd_q, rem_q, quo_q, rem_nxt, quo_nxt;
  logic [SW-1:0] step_q;
  logic          busy_q, fits;
  logic [CW:0]   trial, diff;

  assign trial      = {rem_q, dvd_q[CW-1]};
  assign fits       = trial >= {1'b0, dvs_q};
  assign diff       = trial - {1'b0, dvs_q};
  assign rem_nxt    = fits ? diff[CW-1:0] : trial[CW-1:0];
  assign quo_nxt    = {quo_q[CW-2:0], fits};
  assign in_ready_o = !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dvs_q <= '0; dvd_q <= '0; rem_q <= '0; quo_q <= '0;
      step_q <= '0; busy_q <= 1'b0; out_valid_o <= 1'b0; result_o <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (in_valid_i && !busy_q) begin
        dvs_q <= divisor_i;
        quo_q <= '0;
        if (divisor_i == '0) begin
          result_o    <= '1;
          out_valid_o <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= '0;
          dvd_q  <= CW'(1) << WIN_LOG2;
          step_q <= '0;
        end
      end else if (busy_q) begin
        rem_q  <= rem_nxt;
        quo_q  <= quo_nxt;
        dvd_q  <= dvd_q << 1;
        step_q <= step_q + 1'b1;
        if (step_q == SW'(WIN_LOG2)) begin
          busy_q      <= 1'b0;
          out_valid_o <= 1'b1;
          result_o    <= (quo_nxt > OUT_MAX) ? '1 : quo_nxt[OUT_W-1:0];
        end
      end
    end
  end

  logic [2*CW-1:0] prod_lo, prod_hi, dividend_w;
  always_comb begin
    prod_lo    = (2*CW)'(quo_q) * (2*CW)'(dvs_q);
    prod_hi    = prod_lo + (2*CW)'(dvs_q);
    dividend_w = (2*CW)'(1) << WIN_LOG2;
  end

  AST_QUOTIENT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && dvs_q != '0) |-> (prod_lo <= dividend_w && prod_hi > dividend_w)); // R2
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && dvs_q != '0 && quo_q > OUT_MAX) |-> (result_o == '1)); // R4
endmodule

// File: rtl/cpi_display.sv
module cpi_display
  import cpi_pkg::*;
#(
  parameter int REFRESH_DIV = 33333,
  parameter int BLINK_HALF  = 25000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] value_i,
  input  logic             err_active_i,
  output logic [6:0]       seg_n_o,
  output logic [DIGITS-1:0] an_n_o,
  output logic             blink_o
);
  localparam int PW = $clog2(REFRESH_DIV);
  localparam int BW = $clog2(BLINK_HALF);
  localparam int IW = $clog2(DIGITS);

  logic [PW-1:0]     pre_q;
  logic [BW-1:0]     blk_q;
  logic [IW-1:0]     idx_q, idx_nxt;
  logic              tick;
  logic [DIGITS-1:0] an_sel;
  logic [3:0]        nib;

  assign tick    = (pre_q == PW'(REFRESH_DIV - 1));
  assign idx_nxt = (idx_q == IW'(DIGITS - 1)) ? '0 : idx_q + 1'b1;
  assign nib     = 4'(value_i >> (4 * idx_nxt));

  for (genvar g = 0; g < DIGITS; g++) begin : g_anode
    assign an_sel[g] = (idx_nxt == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      idx_q   <= '0;
      an_n_o  <= ~DIGITS'(1);
      seg_n_o <= ~hex_to_seg(4'h0);
    end else if (tick) begin
      pre_q   <= '0;
      idx_q   <= idx_nxt;
      an_n_o  <= ~an_sel;
      seg_n_o <= ~hex_to_seg(nib);
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !err_active_i) begin
      blk_q   <= '0;
      blink_o <= 1'b0;
    end else if (blk_q == BW'(BLINK_HALF - 1)) begin
      blk_q   <= '0;
      blink_o <= !blink_o;
    end else begin
      blk_q <= blk_q + 1'b1;
    end
  end

  AST_ONE_ANODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(~an_n_o)); // R5
  AST_ANODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q != PW'(REFRESH_DIV - 1)) |=> $stable(an_n_o)); // R5
  AST_BLINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !err_active_i |=> !blink_o); // R8
endmodule

// File: rtl/cpi_status_monitor.sv
module cpi_status_monitor
  import cpi_pkg::*;
#(
  parameter int WIN_LOG2    = 20,
  parameter int REFRESH_DIV = 33333,
  parameter int BLINK_HALF  = 25000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        retire_i,
  input  logic        cal_done_i,
  input  logic        boot_done_i,
  input  logic [11:0] err_code_i,
  output logic [6:0]  seg_o,
  output logic [2:0]  an_o,
  output logic [7:0]  led_o
);
  logic              win_valid, div_ready, div_valid, blink, cal_q, boot_q, err_active;
  logic [WIN_LOG2:0] win_count;
  logic [VAL_W-1:0]  div_result, cpi_q, shown;

  cpi_window #(.WIN_LOG2(WIN_LOG2)) u_window (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i),
    .win_valid_o(win_valid), .win_count_o(win_count));

  cpi_divider #(.WIN_LOG2(WIN_LOG2), .OUT_W(VAL_W)) u_divider (
    .clk(clk), .rst_n(rst_n), .in_valid_i(win_valid), .in_ready_o(div_ready),
    .divisor_i(win_count), .out_valid_o(div_valid), .result_o(div_result));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpi_q  <= '0;
      cal_q  <= 1'b0;
      boot_q <= 1'b0;
    end else begin
      cal_q  <= cal_done_i;
      boot_q <= boot_done_i;
      if (div_valid) cpi_q <= div_result;
    end
  end

  assign err_active = (err_code_i != '0);
  assign shown      = err_active ? err_code_i : cpi_q;

  cpi_display #(.REFRESH_DIV(REFRESH_DIV), .BLINK_HALF(BLINK_HALF)) u_display (
    .clk(clk), .rst_n(rst_n), .value_i(shown), .err_active_i(err_active),
    .seg_n_o(seg_o), .an_n_o(an_o), .blink_o(blink));

  assign led_o = {cal_q, 4'b0000, boot_q, 1'b0, blink};

  AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> div_ready); // R2
  AST_IDLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_count == '0) |=> ##1 (cpi_q == 12'hFFF)); // R3
endmodule

// File: tb/test_cpi_status_monitor.sv
module test_cpi_status_monitor;
  localparam int WL  = 13;
  localparam int RD  = 4;
  localparam int BH  = 16;
  localparam int WIN = 1 << WL;

  logic clk = 1'b0, rst_n = 1'b0, retire = 1'b0, cal = 1'b0, boot = 1'b0;
  logic [11:0] err = '0;
  logic [6:0] seg;
  logic [2:0] an;
  logic [7:0] led;

  always #2.5 clk = !clk;

  cpi_status_monitor #(.WIN_LOG2(WL), .REFRESH_DIV(RD), .BLINK_HALF(BH)) i_cpi_status_monitor (
    .clk(clk), .rst_n(rst_n), .retire_i(retire), .cal_done_i(cal), .boot_done_i(boot),
    .err_code_i(err), .seg_o(seg), .an_o(an), .led_o(led));

  int checks = 0, errors = 0;
  int period = 0;

  typedef struct { logic [11:0] val; string req; } exp_t;
  exp_t q[$];
  bit mon_busy = 0;

  function automatic logic [6:0] seg_of(input logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F,7'h06,7'h5B,7'h4F,7'h66,7'h6D,7'h7D,7'h07,
                           7'h7F,7'h6F,7'h77,7'h7C,7'h39,7'h5E,7'h79,7'h71};
    return ~t[n];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_display(input logic [11:0] v, input string req);
    exp_t e;
    e.val = v; e.req = req;
    q.push_back(e);
    wait (q.size() == 0 && !mon_busy);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // retire generator: one retire every `period` cycles, none when 0
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      retire = (period != 0) && (cnt % period == 0);
      cnt++;
    end
  end

  // monitor: collect each digit and compare with the expected nibble
  initial begin
    forever begin
      exp_t e;
      wait (q.size() > 0);
      mon_busy = 1;
      e = q.pop_front();
      for (int d = 0; d < 3; d++) begin
        do @(negedge clk); while (an != ~(3'b001 << d));
        check(seg == seg_of(e.val[4*d +: 4]), $sformatf("%s digit%0d", e.req, d),
              int'(seg), int'(seg_of(e.val[4*d +: 4])));
      end
      mon_busy = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    summary();
  end

  task automatic run_pattern(input int p);
    period = p;
    repeat (2 * WIN + 3 * WL) @(negedge clk);
  endtask

  initial begin
    int ones, zeros;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(an == 3'b110, "R1 anode", an, 3'b110);
    check(led == 8'h00, "R1 leds", led, 0);
    check(seg == seg_of(4'h0), "R1 seg", seg, seg_of(4'h0));
    expect_display(12'h000, "R1");

    run_pattern(1);     expect_display(12'h001, "R2 every cycle");
    run_pattern(16);    expect_display(12'h010, "R2 period16");
    expect_display(12'h010, "R5 repeat scan");

    cal = 1'b1; repeat (3) @(negedge clk);
    check(led == 8'h80, "R6 cal", led, 8'h80);
    boot = 1'b1; repeat (3) @(negedge clk);
    check(led == 8'h84, "R6 boot", led, 8'h84);

    err = 12'hA5C; repeat (3 * RD + 2) @(negedge clk);
    expect_display(12'hA5C, "R7 error shown");
    ones = 0; zeros = 0;
    for (int i = 0; i < 4 * BH; i++) begin
      @(negedge clk);
      if (led[0]) ones++; else zeros++;
    end
    check(ones > 0 && zeros > 0, "R8 blink", ones, 2 * BH);
    err = 12'h000; repeat (3) @(negedge clk);
    check(led[0] == 1'b0, "R8 blink off", led[0], 0);
    repeat (3 * RD + 2) @(negedge clk);
    expect_display(12'h010, "R9 restore");

    run_pattern(2048);  expect_display(12'h800, "R2 period2048");
    run_pattern(4096);  expect_display(12'hFFF, "R4 saturate");
    run_pattern(0);     expect_display(12'hFFF, "R3 no retire");
    check(led == 8'h84, "R6 steady", led, 8'h84);
    summary();
  end
endmodule